// File: doc/BRIEF.md
# Serial Register Access Front End

This block is a serial-bus slave (SPI, mode 0) that sits between an external host and the register space of a peripheral. Each transaction is framed by chip select going low. The first byte on the data-in line is a header. Its top bit selects read or write, the next bit selects single or burst access, and the low six bits give an address. The block turns the header and the data bytes that follow into one-clock requests on three internal ports:

- a register-file port with shared address, write data, write enable and read enable;
- a read-only status-register port;
- a command-strobe output.

While the host shifts in the header, the block shifts out a chip status byte. The byte is built from a not-ready flag, a 3-bit state code and a 4-bit FIFO fill count, all of which arrive as inputs.

One address window, 0x30 to 0x3D by default, is shared. In that window a header with the burst bit clear issues a command strobe. A read header with the burst bit set reads one status register. A burst header outside the window loads an address counter that advances after every data byte, wrapping within the 6-bit space. The serial clock, chip select and data-in lines are resynchronized to the system clock, and all decisions are made on the synchronized edges. The serial clock must therefore be several system clocks per half period.

Top module: `rif_spi_front`

## Requirements
- R1: Bits are transferred most significant first. Header bit 7 is read (1) / write (0), bit 6 is burst, and bits 5:0 are the address. A single write (header 0x00|addr) followed by a data byte produces exactly one register-file write of that byte to that address. Any further bytes in the same transaction cause no access.
- R2: During the header byte, data-out carries the status byte sampled when chip select falls. Bit 7 is the not-ready flag, bits 6:4 are the state code and bits 3:0 are the FIFO count.
- R3: During each data byte of a write transaction, data-out carries the status byte.
- R4: A burst write (header 0x40|addr) writes successive data bytes to addr, addr+1, addr+2 and so on, wrapping from 0x3F to 0x00.
- R5: A single read (header 0x80|addr, addr outside the window) returns the register at addr in the next byte. Later bytes return the status byte and cause no access.
- R6: A burst read (header 0xC0|addr, addr outside the window) returns the registers at successive addresses in successive bytes, wrapping from 0x3F to 0x00.
- R7: A header whose address lies in the window and whose burst bit is clear, with either value of bit 7, raises the strobe output for one clock with that address when the header completes. It causes no register access, and later bytes are ignored.
- R8: A header 0xC0|addr with addr in the window issues one status-port read at addr. The next byte returns that status data, and later bytes return the status byte with no further access.
- R9: A burst write header whose address lies in the window has no effect: no register write, no strobe and no status read for any byte.
- R10: Chip select going high ends the transaction and discards any partial byte. The next chip-select low starts a fresh header. No request is issued while chip select is high.
- R11: Register write, register read, status read and strobe are each one-clock pulses, and no two are active in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low while not selected |
| st_not_ready | input | 1 | Not-ready flag for the status byte |
| st_state | input | 3 | State code for the status byte |
| st_fifo | input | 4 | FIFO fill count for the status byte |
| rf_addr | output | 6 | Register-file address for reads and writes |
| rf_we | output | 1 | Register-file write pulse |
| rf_wdata | output | 8 | Register-file write data |
| rf_re | output | 1 | Register-file read pulse; data expected on rf_rdata one clock later |
| rf_rdata | input | 8 | Register-file read data |
| sr_re | output | 1 | Status-register read pulse |
| sr_addr | output | 6 | Status-register address |
| sr_rdata | input | 8 | Status-register read data, expected one clock after sr_re |
| cmd_valid | output | 1 | Command strobe pulse |
| cmd_addr | output | 6 | Command strobe address |

## Verification
The checker watches, on every clock, the properties that hold regardless of traffic:
- request pulses last one clock and never overlap;
- strobe and status-read addresses stay inside the shared window;
- nothing is requested once chip select has been high for a few clocks.

What only the bench scenarios can show is the byte-level meaning of a transaction:
- the status byte and read data appear bit by bit on data-out;
- burst addresses advance and wrap;
- single accesses stop after one data byte;
- window headers with the wrong burst or direction bits are dropped;
- a transaction cut short by chip select leaves no trace.

// File: rtl/rif_pkg.sv
package rif_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_WR,
        PH_RD,
        PH_STAT,
        PH_DROP
    } phase_e;

    typedef struct packed {
        logic              rnw;
        logic              burst;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic       not_rdy;
        logic [2:0] state;
        logic [3:0] fifo;
    } stat_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/rif_sync.sv
module rif_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rif_shift.sv
module rif_shift
    import rif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic              s_rise,
    input  logic              s_fall,
    input  logic              sd_in,
    input  logic [BYTE_W-1:0] first_byte,
    input  logic [BYTE_W-1:0] next_byte,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sd_out
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] rx;
    logic [BYTE_W-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            rx  <= '0;
            tx  <= '0;
        end else if (start) begin
            cnt <= '0;
            tx  <= first_byte;
        end else if (active) begin
            if (s_rise) begin
                rx  <= {rx[BYTE_W-3:0], sd_in};
                cnt <= cnt + CNT_W'(1);
            end
            if (s_fall) begin
                // a fall with the counter at zero opens a new byte
                if (cnt == '0) tx <= next_byte;
                else           tx <= {tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign done    = active && s_rise && (cnt == LAST);
    assign rx_byte = {rx, sd_in};
    assign sd_out  = tx[BYTE_W-1];
endmodule

// File: rtl/rif_spi_front.sv
module rif_spi_front
    import rif_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] WIN_LO      = 6'h30,
    parameter logic [ADDR_W-1:0] WIN_HI      = 6'h3D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              st_not_ready,
    input  logic [2:0]        st_state,
    input  logic [3:0]        st_fifo,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic              rf_re,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              sr_re,
    output logic [ADDR_W-1:0] sr_addr,
    input  logic [BYTE_W-1:0] sr_rdata,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int N_SYNC = 3;
    localparam int IDX_CS = 2;
    localparam int IDX_CK = 1;
    localparam int IDX_DI = 0;

    logic [N_SYNC-1:0] raw, syn;
    assign raw = {spi_cs_n, spi_sclk, spi_mosi};

    for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
        rif_sync #(.STAGES(SYNC_STAGES), .INIT(gi == IDX_CS)) u_sync (
            .clk(clk), .rst(rst), .din(raw[gi]), .q(syn[gi])
        );
    end

    logic cs_prev, ck_prev;
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev <= 1'b1;
            ck_prev <= 1'b0;
        end else begin
            cs_prev <= syn[IDX_CS];
            ck_prev <= syn[IDX_CK];
        end
    end

    logic active, cs_start, cs_end, ck_rise, ck_fall;
    assign active   = ~syn[IDX_CS];
    assign cs_start = ~syn[IDX_CS] & cs_prev;
    assign cs_end   =  syn[IDX_CS] & ~cs_prev;
    assign ck_rise  =  syn[IDX_CK] & ~ck_prev;
    assign ck_fall  = ~syn[IDX_CK] & ck_prev;

    stat_t now_stat;
    assign now_stat = '{not_rdy: st_not_ready, state: st_state, fifo: st_fifo};

    logic              byte_done, sd_out;
    logic [BYTE_W-1:0] rx_byte, nxt_q;

    rif_shift u_shift (
        .clk(clk), .rst(rst), .start(cs_start), .active(active),
        .s_rise(ck_rise), .s_fall(ck_fall), .sd_in(syn[IDX_DI]),
        .first_byte(now_stat), .next_byte(nxt_q),
        .done(byte_done), .rx_byte(rx_byte), .sd_out(sd_out)
    );

    hdr_t hdr_w;
    assign hdr_w = hdr_t'(rx_byte);

    phase_e            phase;
    logic              burst_q, pend_rf, pend_sr;
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            burst_q   <= 1'b0;
            cnt_q     <= '0;
            nxt_q     <= '0;
            pend_rf   <= 1'b0;
            pend_sr   <= 1'b0;
            rf_we     <= 1'b0;
            rf_wdata  <= '0;
            rf_re     <= 1'b0;
            sr_re     <= 1'b0;
            sr_addr   <= '0;
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
        end else begin
            rf_we     <= 1'b0;
            rf_re     <= 1'b0;
            sr_re     <= 1'b0;
            cmd_valid <= 1'b0;
            pend_rf   <= rf_re;
            pend_sr   <= sr_re;
            if (pend_rf) nxt_q <= rf_rdata;
            if (pend_sr) nxt_q <= sr_rdata;
            if (rf_we && burst_q) cnt_q <= cnt_q + ADDR_W'(1);

            if (cs_end) begin
                phase <= PH_IDLE;
            end else if (cs_start) begin
                phase <= PH_HDR;
            end else if (byte_done) begin
                nxt_q <= now_stat;
                unique case (phase)
                    PH_HDR: begin
                        cnt_q   <= hdr_w.addr;
                        burst_q <= hdr_w.burst;
                        if (in_window(hdr_w.addr, WIN_LO, WIN_HI)) begin
                            if (!hdr_w.burst) begin
                                cmd_valid <= 1'b1;
                                cmd_addr  <= hdr_w.addr;
                                phase     <= PH_DROP;
                            end else if (hdr_w.rnw) begin
                                sr_re   <= 1'b1;
                                sr_addr <= hdr_w.addr;
                                phase   <= PH_STAT;
                            end else begin
                                phase <= PH_DROP;
                            end
                        end else if (hdr_w.rnw) begin
                            rf_re <= 1'b1;
                            phase <= PH_RD;
                        end else begin
                            phase <= PH_WR;
                        end
                    end
                    PH_WR: begin
                        rf_we    <= 1'b1;
                        rf_wdata <= rx_byte;
                        if (!burst_q) phase <= PH_DROP;
                    end
                    PH_RD: begin
                        if (burst_q) begin
                            cnt_q <= cnt_q + ADDR_W'(1);
                            rf_re <= 1'b1;
                        end else begin
                            phase <= PH_DROP;
                        end
                    end
                    default: phase <= PH_DROP;
                endcase
            end
        end
    end

    assign rf_addr  = cnt_q;
    assign spi_miso = active & sd_out;
endmodule

// File: rtl/rif_spi_front_chk.sv
module rif_spi_front_chk
    import rif_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_LO = 6'h30,
    parameter logic [ADDR_W-1:0] WIN_HI = 6'h3D
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_cs_n,
    input logic              rf_we,
    input logic              rf_re,
    input logic              sr_re,
    input logic [ADDR_W-1:0] sr_addr,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_addr
);
    p_cmd_window_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr >= WIN_LO && cmd_addr <= WIN_HI));

    p_sr_window_r8: assert property (@(posedge clk) disable iff (rst)
        sr_re |-> (sr_addr >= WIN_LO && sr_addr <= WIN_HI));

    p_we_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, rf_re, sr_re, cmd_valid}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4) && $past(spi_cs_n, 5))
        |-> !(rf_we || rf_re || sr_re || cmd_valid));
endmodule

bind rif_spi_front rif_spi_front_chk #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n),
    .rf_we(rf_we), .rf_re(rf_re), .sr_re(sr_re), .sr_addr(sr_addr),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr)
);

// File: tb/rif_spi_front_test.sv
module rif_spi_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0, rst = 1'b1;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic       st_nr = 1'b0;
    logic [2:0] st_st = '0;
    logic [3:0] st_ff = '0;
    logic [5:0] rf_addr, sr_addr, cmd_addr;
    logic       rf_we, rf_re, sr_re, cmd_valid;
    logic [7:0] rf_wdata, rf_rdata, sr_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    rif_spi_front uut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .st_not_ready(st_nr), .st_state(st_st), .st_fifo(st_ff),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_re(rf_re),
        .rf_rdata(rf_rdata), .sr_re(sr_re), .sr_addr(sr_addr), .sr_rdata(sr_rdata),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7) + 3);
    endfunction

    function automatic logic [7:0] sr_model(input logic [5:0] a);
        return {2'b10, a} ^ 8'h0F;
    endfunction

    // external register file and status registers, one-clock read latency
    logic [7:0] mem [64];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
            rf_rdata <= '0;
            sr_rdata <= '0;
        end else begin
            if (rf_re) rf_rdata <= mem[rf_addr];
            if (sr_re) sr_rdata <= sr_model(sr_addr);
            if (rf_we) mem[rf_addr] <= rf_wdata;
        end
    end

    int n_chk = 0, n_fail = 0, n_evt = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  shadow [64];
    bit          done_flag = 0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: kind 1 write, 2 strobe, 3 status read
    task automatic sb_pop(input logic [15:0] got);
        n_evt++;
        if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 unexpected request act=%h exp=none", got);
        end else begin
            check(tag_q.pop_front(), got, exp_q.pop_front());
        end
    endtask

    logic prev_we = 0, prev_cmd = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rf_we)     sb_pop({2'd1, rf_addr, rf_wdata});
            if (cmd_valid) sb_pop({2'd2, cmd_addr, 8'h00});
            if (sr_re)     sb_pop({2'd3, sr_addr, 8'h00});
            if (prev_we)  check("R11 write pulse width", 16'(rf_we), 16'h0);
            if (prev_cmd) check("R11 strobe pulse width", 16'(cmd_valid), 16'h0);
            prev_we  = rf_we;
            prev_cmd = cmd_valid;
        end
    end

    task automatic push(input string tag, input logic [1:0] k, input logic [5:0] a, input logic [7:0] d);
        exp_q.push_back({k, a, d});
        tag_q.push_back(tag);
    endtask

    task automatic spi_bits(input logic [7:0] mo, input int n, output logic [7:0] mi);
        mi = '0;
        for (int b = 7; b > 7 - n; b--) begin
            mosi = mo[b];
            repeat (HALF) @(negedge clk);
            mi[b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] mo, output logic [7:0] mi);
        spi_bits(mo, 8, mi);
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic set_stat(input logic nr, input logic [2:0] s, input logic [3:0] f);
        st_nr = nr; st_st = s; st_ff = f;
    endtask

    function automatic logic [15:0] sb_stat();
        return {8'h00, st_nr, st_st, st_ff};
    endfunction

    initial begin
        logic [7:0] mi;
        int evt0;
        for (int i = 0; i < 64; i++) shadow[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // reset state
        check("R10 reset miso", 16'(miso), 16'h0);
        check("R11 reset requests", {12'h0, rf_we, rf_re, sr_re, cmd_valid}, 16'h0);

        // R1/R2/R3: single write, then an extra byte that must be ignored
        set_stat(1'b0, 3'b010, 4'h5);
        push("R1 single write", 2'd1, 6'h05, 8'h5A); shadow[5] = 8'h5A;
        cs_low();
        xbyte(8'h05, mi); check("R2 header status", 16'(mi), sb_stat());
        xbyte(8'h5A, mi); check("R3 write status", 16'(mi), sb_stat());
        xbyte(8'h99, mi); check("R1 extra byte status", 16'(mi), sb_stat());
        cs_high();

        // R4: burst write across the wrap point
        set_stat(1'b1, 3'b101, 4'hC);
        push("R4 burst wr 3E", 2'd1, 6'h3E, 8'h11); shadow[62] = 8'h11;
        push("R4 burst wr 3F", 2'd1, 6'h3F, 8'h22); shadow[63] = 8'h22;
        push("R4 burst wr 00", 2'd1, 6'h00, 8'h33); shadow[0]  = 8'h33;
        cs_low();
        xbyte(8'h7E, mi); check("R2 header status burst", 16'(mi), sb_stat());
        xbyte(8'h11, mi); check("R3 burst status 0", 16'(mi), sb_stat());
        xbyte(8'h22, mi); check("R3 burst status 1", 16'(mi), sb_stat());
        xbyte(8'h33, mi); check("R3 burst status 2", 16'(mi), sb_stat());
        cs_high();

        // R5: single read
        set_stat(1'b0, 3'b001, 4'h3);
        cs_low();
        xbyte(8'h85, mi); check("R2 header status read", 16'(mi), sb_stat());
        xbyte(8'h00, mi); check("R5 single read data", 16'(mi), 16'(shadow[5]));
        xbyte(8'h00, mi); check("R5 after single read", 16'(mi), sb_stat());
        cs_high();

        // R6: burst read across wrap
        cs_low();
        xbyte(8'hFE, mi);
        xbyte(8'h00, mi); check("R6 burst rd 3E", 16'(mi), 16'(shadow[62]));
        xbyte(8'h00, mi); check("R6 burst rd 3F", 16'(mi), 16'(shadow[63]));
        xbyte(8'h00, mi); check("R6 burst rd 00", 16'(mi), 16'(shadow[0]));
        xbyte(8'h00, mi); check("R6 burst rd 01", 16'(mi), 16'(shadow[1]));
        cs_high();

        // R7: strobes, write-type and read-type, trailing byte ignored
        set_stat(1'b0, 3'b110, 4'h9);
        push("R7 strobe 36", 2'd2, 6'h36, 8'h00);
        cs_low();
        xbyte(8'h36, mi); check("R2 header status strobe", 16'(mi), sb_stat());
        xbyte(8'hAB, mi); check("R7 byte after strobe", 16'(mi), sb_stat());
        cs_high();
        push("R7 strobe 33 rnw", 2'd2, 6'h33, 8'h00);
        cs_low();
        xbyte(8'hB3, mi);
        cs_high();

        // R8: status register read, only one
        push("R8 status read 31", 2'd3, 6'h31, 8'h00);
        cs_low();
        xbyte(8'hF1, mi);
        xbyte(8'h00, mi); check("R8 status data", 16'(mi), 16'(sr_model(6'h31)));
        xbyte(8'h00, mi); check("R8 no second status", 16'(mi), sb_stat());
        cs_high();

        // R9: burst write header inside the window has no effect
        evt0 = n_evt;
        cs_low();
        xbyte(8'h72, mi);
        xbyte(8'h44, mi); check("R9 window burst write status", 16'(mi), sb_stat());
        xbyte(8'h55, mi);
        cs_high();
        check("R9 no request", 16'(n_evt - evt0), 16'h0);

        // R10: transaction cut mid data byte, then cut mid header
        evt0 = n_evt;
        cs_low();
        xbyte(8'h07, mi);
        spi_bits(8'hF0, 4, mi);
        cs_high();
        cs_low();
        spi_bits(8'hF0, 4, mi);
        cs_high();
        check("R10 cut transactions", 16'(n_evt - evt0), 16'h0);
        push("R10 fresh header write", 2'd1, 6'h08, 8'h66); shadow[8] = 8'h66;
        cs_low();
        xbyte(8'h08, mi);
        xbyte(8'h66, mi);
        cs_high();
        cs_low();
        xbyte(8'h88, mi);
        xbyte(8'h00, mi); check("R10 readback after restart", 16'(mi), 16'(shadow[8]));
        cs_high();
        cs_low();
        xbyte(8'h87, mi);
        xbyte(8'h00, mi); check("R10 cut write left reg", 16'(mi), 16'(shadow[7]));
        cs_high();

        check("R11 scoreboard drained", 16'(exp_q.size()), 16'h0);

        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule